// File: doc/BRIEF.md
# Predicated Vector Lane Unit

This block is a single-stage integer vector execution unit built from 32-bit lanes. The vector width is fixed when the block is built. It has two jobs. First, it produces loop-control predicates: it compares a scalar loop index plus the lane number against a loop bound and reports which lanes still fall inside the loop. Second, it runs element-wise arithmetic on the lanes that a predicate enables. The operations are a lane-by-lane add and a multiply by one broadcast scalar.

A loop controller issues one command per iteration on a valid/ready port. Each command carries an opcode, two vector sources, a scalar, the index and bound, an explicit predicate, and two mode bits. One mode bit selects whether the governing predicate is the explicit one or the one generated from index and bound. The other mode bit selects merging or zeroing for lanes that are switched off. The result arrives one cycle later on its own valid. It carries the result vector, the governing predicate, and two summary flags (first lane active, any lane active) that the controller uses to end the loop. A tail iteration gets a partly true predicate, so the loop needs no scalar clean-up pass.

Lane k occupies vector bits [32k+31:32k] and predicate bit k. Elements are plain two's-complement integers.

Top module: `vec_lane_unit`

## Requirements
- R1: While rstN is low, resValid, resVec and resPred are all zero and cmdReady is low. cmdReady is high from the first clock edge after reset is released.
- R2: A command is accepted on a rising edge where cmdValid and cmdReady are both high. Its result is presented with resValid high in the following cycle. resValid is low after any edge without an accept, and resVec and resPred hold their values until the next accept.
- R3: Opcode 0 (predicate generation) sets predicate bit k to 1 exactly when cmdIdx + k < cmdBound. The comparison treats both values as signed and uses exact arithmetic, so the sum never wraps. The result vector is all zeros.
- R4: For a tail iteration with cmdIdx = cmdBound - 2, opcode 0 sets only the two lowest predicate bits.
- R5: Opcode 1 (add) writes, on each active lane, the sum of the two source lanes modulo 2^32. In merging mode (cmdZero = 0), an inactive lane outputs its cmdSrcA lane unchanged.
- R6: Opcode 2 (scalar multiply) writes, on each active lane, the low 32 bits of the cmdSrcA lane times cmdScalar. cmdSrcB has no effect.
- R7: With cmdZero = 1, every inactive lane of opcode 1 or 2 outputs zero.
- R8: For opcodes 1 and 2, the governing predicate is the generated one (the rule of R3) when cmdUseGen = 1 and cmdPred otherwise. resPred reports the governing predicate.
- R9: resFirst equals predicate bit 0 of the result, and resAny is high when any result predicate bit is high.
- R10: Opcode 3 is a no-op that yields an all-zero vector and an all-zero predicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Unit can take a command |
| cmdOp | input | 2 | 0 predicate gen, 1 add, 2 scalar multiply, 3 no-op |
| cmdZero | input | 1 | 1 zeroing, 0 merging for inactive lanes |
| cmdUseGen | input | 1 | 1 govern by generated predicate, 0 by cmdPred |
| cmdPred | input | VEC_BITS/32 | Explicit governing predicate |
| cmdSrcA | input | VEC_BITS | First vector source, merge value |
| cmdSrcB | input | VEC_BITS | Second vector source for add |
| cmdScalar | input | 32 | Broadcast multiplier |
| cmdIdx | input | 32 | Signed loop index |
| cmdBound | input | 32 | Signed loop bound |
| resValid | output | 1 | Result present |
| resVec | output | VEC_BITS | Result vector |
| resPred | output | VEC_BITS/32 | Result predicate |
| resFirst | output | 1 | Lane 0 of result predicate active |
| resAny | output | 1 | Some result predicate lane active |

## Verification
The bench drives each command at a falling edge. The command is accepted at the next rising edge, and the outputs are sampled at the falling edge after that. That is where the result of the single output register stage must be visible. At the falling edge one full cycle later, with no command driven and cmdSrcA disturbed, the bench checks that resValid has dropped and that resVec and resPred still hold. It checks the reset values at a falling edge during reset, and it checks cmdReady at the first falling edge after release.

// File: rtl/vlu_pkg.sv
package vlu_pkg;

  localparam int unsigned ELEM_BITS = 32;

  typedef enum logic [1:0] {
    OP_WHILE = 2'd0,
    OP_ADD   = 2'd1,
    OP_MULS  = 2'd2,
    OP_NONE  = 2'd3
  } vluOp_e;

  typedef struct packed {
    logic load;
    logic genOnly;
    logic arith;
    logic doMul;
    logic zeroing;
    logic useGen;
  } vluStrobe_t;

endpackage

// File: rtl/vlu_ctrl.sv
module vlu_ctrl
  import vlu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cmdZero,
  input  logic       cmdUseGen,
  output logic       cmdReady,
  output logic       resValid,
  output vluStrobe_t strobe
);

  logic   readyQ;
  logic   validQ;
  logic   accept;
  vluOp_e opCode;

  assign opCode = vluOp_e'(cmdOp);
  assign accept = cmdValid && readyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      validQ <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      validQ <= accept;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.load    = accept;
    strobe.zeroing = cmdZero;
    strobe.useGen  = cmdUseGen;
    unique case (opCode)
      OP_WHILE: strobe.genOnly = 1'b1;
      OP_ADD:   strobe.arith   = 1'b1;
      OP_MULS: begin
        strobe.arith = 1'b1;
        strobe.doMul = 1'b1;
      end
      OP_NONE:  ;
      default:  ;
    endcase
  end

  assign cmdReady = readyQ;
  assign resValid = validQ;

endmodule

// File: rtl/vlu_datapath.sv
module vlu_datapath
  import vlu_pkg::*;
#(
  parameter int unsigned VEC_BITS = 256,
  localparam int unsigned LANES   = VEC_BITS / ELEM_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  vluStrobe_t           strobe,
  input  logic [LANES-1:0]     cmdPred,
  input  logic [VEC_BITS-1:0]  cmdSrcA,
  input  logic [VEC_BITS-1:0]  cmdSrcB,
  input  logic [ELEM_BITS-1:0] cmdScalar,
  input  logic [ELEM_BITS-1:0] cmdIdx,
  input  logic [ELEM_BITS-1:0] cmdBound,
  output logic [VEC_BITS-1:0]  resVec,
  output logic [LANES-1:0]     resPred,
  output logic                 resFirst,
  output logic                 resAny
);

  localparam int unsigned EXT_BITS = ELEM_BITS + 2;

  logic [EXT_BITS-1:0] idxExt;
  logic [EXT_BITS-1:0] boundExt;
  logic [LANES-1:0]    genPred;
  logic [LANES-1:0]    govPred;
  logic [LANES-1:0]    predNext;
  logic [VEC_BITS-1:0] vecNext;
  logic [VEC_BITS-1:0] vecQ;
  logic [LANES-1:0]    predQ;

  assign idxExt   = {{2{cmdIdx[ELEM_BITS-1]}}, cmdIdx};
  assign boundExt = {{2{cmdBound[ELEM_BITS-1]}}, cmdBound};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [EXT_BITS-1:0]  laneIdx;
    logic [ELEM_BITS-1:0] opA;
    logic [ELEM_BITS-1:0] opB;
    logic [ELEM_BITS-1:0] sum;
    logic [ELEM_BITS-1:0] prod;
    logic [ELEM_BITS-1:0] calc;
    logic [ELEM_BITS-1:0] idle;

    assign laneIdx    = idxExt + EXT_BITS'(g);
    assign genPred[g] = $signed(laneIdx) < $signed(boundExt);
    assign govPred[g] = strobe.useGen ? genPred[g] : cmdPred[g];

    assign opA  = cmdSrcA[g*ELEM_BITS +: ELEM_BITS];
    assign opB  = cmdSrcB[g*ELEM_BITS +: ELEM_BITS];
    assign sum  = opA + opB;
    assign prod = opA * cmdScalar;
    assign calc = strobe.doMul ? prod : sum;
    assign idle = strobe.zeroing ? '0 : opA;

    assign vecNext[g*ELEM_BITS +: ELEM_BITS] =
      !strobe.arith ? '0 : (govPred[g] ? calc : idle);
  end

  always_comb begin
    if (strobe.genOnly)    predNext = genPred;
    else if (strobe.arith) predNext = govPred;
    else                   predNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ  <= '0;
      predQ <= '0;
    end else if (strobe.load) begin
      vecQ  <= vecNext;
      predQ <= predNext;
    end
  end

  assign resVec   = vecQ;
  assign resPred  = predQ;
  assign resFirst = predQ[0];
  assign resAny   = |predQ;

endmodule

// File: rtl/vec_lane_unit.sv
module vec_lane_unit
  import vlu_pkg::*;
#(
  parameter int unsigned VEC_BITS = 256,
  localparam int unsigned LANES   = VEC_BITS / ELEM_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  output logic                 cmdReady,
  input  logic [1:0]           cmdOp,
  input  logic                 cmdZero,
  input  logic                 cmdUseGen,
  input  logic [LANES-1:0]     cmdPred,
  input  logic [VEC_BITS-1:0]  cmdSrcA,
  input  logic [VEC_BITS-1:0]  cmdSrcB,
  input  logic [ELEM_BITS-1:0] cmdScalar,
  input  logic [ELEM_BITS-1:0] cmdIdx,
  input  logic [ELEM_BITS-1:0] cmdBound,
  output logic                 resValid,
  output logic [VEC_BITS-1:0]  resVec,
  output logic [LANES-1:0]     resPred,
  output logic                 resFirst,
  output logic                 resAny
);

  vluStrobe_t strobe;

  vlu_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .cmdZero   (cmdZero),
    .cmdUseGen (cmdUseGen),
    .cmdReady  (cmdReady),
    .resValid  (resValid),
    .strobe    (strobe)
  );

  vlu_datapath #(.VEC_BITS(VEC_BITS)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdPred   (cmdPred),
    .cmdSrcA   (cmdSrcA),
    .cmdSrcB   (cmdSrcB),
    .cmdScalar (cmdScalar),
    .cmdIdx    (cmdIdx),
    .cmdBound  (cmdBound),
    .resVec    (resVec),
    .resPred   (resPred),
    .resFirst  (resFirst),
    .resAny    (resAny)
  );

endmodule

// File: rtl/vlu_checker.sv
module vlu_checker #(
  parameter int unsigned VEC_BITS = 256,
  localparam int unsigned LANES   = VEC_BITS / 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic                cmdReady,
  input logic [1:0]          cmdOp,
  input logic                cmdZero,
  input logic                cmdUseGen,
  input logic [LANES-1:0]    cmdPred,
  input logic [31:0]         cmdIdx,
  input logic [31:0]         cmdBound,
  input logic                resValid,
  input logic [VEC_BITS-1:0] resVec,
  input logic [LANES-1:0]    resPred,
  input logic                resFirst,
  input logic                resAny
);

  logic accept;
  assign accept = cmdValid && cmdReady;

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> cmdReady);

  p_valid_after_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> resValid);

  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> !resValid);

  p_hold_result_r2: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> ($stable(resVec) && $stable(resPred)));

  p_loop_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp == 2'd0 && $signed(cmdIdx) >= $signed(cmdBound))
      |=> (!resAny && resPred == '0));

  p_zero_all_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp[1] != cmdOp[0] && cmdZero && !cmdUseGen && cmdPred == '0)
      |=> (resVec == '0));

  p_explicit_pred_r8: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp[1] != cmdOp[0] && !cmdUseGen) |=> (resPred == $past(cmdPred)));

  p_first_implies_any_r9: assert property (@(posedge clk) disable iff (!rstN)
    resFirst |-> resAny);

  p_noop_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp == 2'd3) |=> (resVec == '0 && resPred == '0));

endmodule

bind vec_lane_unit vlu_checker #(.VEC_BITS(VEC_BITS)) i_vlu_checker (
  .clk       (clk),
  .rstN      (rstN),
  .cmdValid  (cmdValid),
  .cmdReady  (cmdReady),
  .cmdOp     (cmdOp),
  .cmdZero   (cmdZero),
  .cmdUseGen (cmdUseGen),
  .cmdPred   (cmdPred),
  .cmdIdx    (cmdIdx),
  .cmdBound  (cmdBound),
  .resValid  (resValid),
  .resVec    (resVec),
  .resPred   (resPred),
  .resFirst  (resFirst),
  .resAny    (resAny)
);

// File: tb/test_vec_lane_unit.sv
`timescale 1ns/1ps
module test_vec_lane_unit;

  localparam int VEC_BITS = 256;
  localparam int LANES    = VEC_BITS / 32;

  logic                clk = 1'b0;
  logic                rstN;
  logic                cmdValid;
  logic                cmdReady;
  logic [1:0]          cmdOp;
  logic                cmdZero;
  logic                cmdUseGen;
  logic [LANES-1:0]    cmdPred;
  logic [VEC_BITS-1:0] cmdSrcA;
  logic [VEC_BITS-1:0] cmdSrcB;
  logic [31:0]         cmdScalar;
  logic [31:0]         cmdIdx;
  logic [31:0]         cmdBound;
  logic                resValid;
  logic [VEC_BITS-1:0] resVec;
  logic [LANES-1:0]    resPred;
  logic                resFirst;
  logic                resAny;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vec_lane_unit #(.VEC_BITS(VEC_BITS)) i_vec_lane_unit (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdZero(cmdZero), .cmdUseGen(cmdUseGen), .cmdPred(cmdPred),
    .cmdSrcA(cmdSrcA), .cmdSrcB(cmdSrcB), .cmdScalar(cmdScalar),
    .cmdIdx(cmdIdx), .cmdBound(cmdBound), .resValid(resValid),
    .resVec(resVec), .resPred(resPred), .resFirst(resFirst), .resAny(resAny)
  );

  task automatic check(string req, string what, logic [VEC_BITS-1:0] act,
                       logic [VEC_BITS-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [LANES-1:0] genPredModel(logic [31:0] idx, logic [31:0] bound);
    logic [LANES-1:0] p;
    for (int k = 0; k < LANES; k++)
      p[k] = (longint'($signed(idx)) + longint'(k)) < longint'($signed(bound));
    return p;
  endfunction

  function automatic logic [LANES-1:0] predModel(logic [1:0] op, logic useGen,
      logic [LANES-1:0] pred, logic [31:0] idx, logic [31:0] bound);
    if (op == 2'd0) return genPredModel(idx, bound);
    if (op == 2'd3) return '0;
    return useGen ? genPredModel(idx, bound) : pred;
  endfunction

  function automatic logic [VEC_BITS-1:0] vecModel(logic [1:0] op, logic zero,
      logic [LANES-1:0] p, logic [VEC_BITS-1:0] a, logic [VEC_BITS-1:0] b,
      logic [31:0] s);
    logic [VEC_BITS-1:0] v = '0;
    if (op == 2'd1 || op == 2'd2) begin
      for (int k = 0; k < LANES; k++) begin
        logic [31:0] ea = a[k*32 +: 32];
        logic [31:0] eb = b[k*32 +: 32];
        logic [63:0] full = 64'(ea) * 64'(s);
        logic [31:0] r;
        if (p[k]) r = (op == 2'd1) ? ea + eb : full[31:0];
        else      r = zero ? 32'd0 : ea;
        v[k*32 +: 32] = r;
      end
    end
    return v;
  endfunction

  function automatic logic [VEC_BITS-1:0] randVec();
    logic [VEC_BITS-1:0] v;
    for (int k = 0; k < LANES; k++) v[k*32 +: 32] = $urandom();
    return v;
  endfunction

  task automatic runCmd(string req, logic [1:0] op, logic zero, logic useGen,
      logic [LANES-1:0] pred, logic [VEC_BITS-1:0] a, logic [VEC_BITS-1:0] b,
      logic [31:0] s, logic [31:0] idx, logic [31:0] bound);
    logic [LANES-1:0]    expP = predModel(op, useGen, pred, idx, bound);
    logic [VEC_BITS-1:0] expV = vecModel(op, zero, expP, a, b, s);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdZero = zero; cmdUseGen = useGen;
    cmdPred = pred; cmdSrcA = a; cmdSrcB = b; cmdScalar = s;
    cmdIdx = idx; cmdBound = bound;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    check("R2", "resValid", VEC_BITS'(resValid), VEC_BITS'(1));
    check(req, "resVec", resVec, expV);
    check(req, "resPred", VEC_BITS'(resPred), VEC_BITS'(expP));
    check("R9", "resFirst", VEC_BITS'(resFirst), VEC_BITS'(expP[0]));
    check("R9", "resAny", VEC_BITS'(resAny), VEC_BITS'(|expP));
    cmdSrcA = randVec();
    @(posedge clk);
    @(negedge clk);
    check("R2", "idle resValid", VEC_BITS'(resValid), VEC_BITS'(0));
    check("R2", "held resVec", resVec, expV);
    check("R2", "held resPred", VEC_BITS'(resPred), VEC_BITS'(expP));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [VEC_BITS-1:0] a;
    logic [VEC_BITS-1:0] b;
    void'($urandom(32'd20240611));
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = '0; cmdZero = 1'b0; cmdUseGen = 1'b0;
    cmdPred = '0; cmdSrcA = '0; cmdSrcB = '0; cmdScalar = '0; cmdIdx = '0; cmdBound = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    check("R1", "cmdReady in reset", VEC_BITS'(cmdReady), VEC_BITS'(0));
    check("R1", "resValid in reset", VEC_BITS'(resValid), VEC_BITS'(0));
    check("R1", "resVec in reset", resVec, '0);
    check("R1", "resPred in reset", VEC_BITS'(resPred), VEC_BITS'(0));
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "cmdReady after reset", VEC_BITS'(cmdReady), VEC_BITS'(1));

    // R5 merging example: 1,2,3,4 + 5,5,5,5 under 1,0,1,0 -> 6,2,8,4
    a = '0; b = '0;
    for (int k = 0; k < LANES; k++) begin
      a[k*32 +: 32] = 32'(k + 1);
      b[k*32 +: 32] = 32'd5;
    end
    runCmd("R5", 2'd1, 1'b0, 1'b0, LANES'('b0101), a, b, 32'd0, 32'd0, 32'd0);
    check("R5", "lane1 merged", VEC_BITS'(resVec[63:32]), VEC_BITS'(2));

    // R4 tail: idx = bound - 2
    runCmd("R4", 2'd0, 1'b0, 1'b0, '0, randVec(), randVec(), 32'd0, 32'd98, 32'd100);
    check("R4", "tail predicate", VEC_BITS'(resPred), VEC_BITS'(3));
    // R3 loop ended, negative values, and no wrap near the top of range
    runCmd("R3", 2'd0, 1'b0, 1'b0, '0, '0, '0, 32'd0, 32'd100, 32'd100);
    runCmd("R3", 2'd0, 1'b0, 1'b0, '0, '0, '0, 32'd0, 32'hFFFF_FFFB, 32'hFFFF_FFFE);
    runCmd("R3", 2'd0, 1'b0, 1'b0, '0, '0, '0, 32'd0, 32'h7FFF_FFFE, 32'h7FFF_FFFF);
    check("R3", "no wrap predicate", VEC_BITS'(resPred), VEC_BITS'(1));
    // R6 scalar multiply with overflow, B ignored
    runCmd("R6", 2'd2, 1'b0, 1'b0, '1, randVec(), randVec(), 32'hDEAD_BEEF, 32'd0, 32'd0);
    // R7 zeroing with generated tail predicate (R8)
    runCmd("R7", 2'd1, 1'b1, 1'b1, '0, randVec(), randVec(), 32'd0, 32'd10, 32'd13);
    runCmd("R8", 2'd2, 1'b0, 1'b1, '1, randVec(), randVec(), 32'd7, 32'd0, 32'd5);
    // R10 no-op
    runCmd("R10", 2'd3, 1'b0, 1'b1, '1, randVec(), randVec(), 32'd3, 32'd0, 32'd50);

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [1:0] op = 2'($urandom_range(0, 3));
      logic [31:0] bnd = 32'($urandom_range(0, 40)) - 32'd10;
      logic [31:0] ix  = 32'($urandom_range(0, 40)) - 32'd10;
      string tag;
      case (op)
        2'd0: tag = "R3";
        2'd1: tag = "R5";
        2'd2: tag = "R6";
        default: tag = "R10";
      endcase
      runCmd(tag, op, 1'($urandom()), 1'($urandom()), LANES'($urandom()),
             randVec(), randVec(), $urandom(), ix, bnd);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule